// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block holds the interrupt flags and the live status byte of a keypad and GPIO expander. Other subsystems send it single-cycle pulses: logic-block outputs, lock and unlock events, FIFO overflow, per-pin GPI hits and key events. Each pulse sets a sticky flag. Software clears a flag by writing 1 to its bit position.

A GPI pin or logic block that is routed to the FIFO raises the shared event flag. It does not raise its own flag. A lock change that software itself caused raises no lock flag. The summary GPI flag cannot be cleared while any per-pin GPI flag is still pending.

Software reads three bytes over a plain address, write-data and read-data port:
- a fixed identity byte;
- the interrupt flags;
- a live status byte with both logic outputs, the lock state and the FIFO event count.

A single registered request line is the OR of the enabled flags.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all six flags are 0, the request output is 0, and address 0x01 reads 0x00.
- R2: Address 0x00 reads {4'b0001, REV} as a read-only byte. With the default parameter REV=1 it reads 0x11.
- R3: Address 0x01 reads the flags with this layout: bit 5 logic 2, bit 4 logic 1, bit 3 lock, bit 2 overflow, bit 1 GPI, bit 0 event. Bits 7:6 read 0.
- R4: A flag stays set until a write to 0x01 with a 1 in its bit position. A write with a 0 in that position leaves the flag unchanged.
- R5: When a source pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: Address 0x02 reads {logic2_lvl, logic1_lvl, locked, evt_count[4:0]}, the live inputs of that cycle.
- R7: A lock_evt pulse sets the lock flag (bit 3), except when lock_sw_cause is high in the same cycle.
- R8: The GPI flag (bit 1) is set by a gpi_hit pin whose gpi_to_fifo bit is 0. A hit on a pin whose gpi_to_fifo bit is 1 does not set it.
- R9: A write-1 clear of bit 1 is ignored while any bit of gpi_pend is 1.
- R10: The event flag (bit 0) is set by any of these:
  - key_evt;
  - a gpi_hit on a pin with gpi_to_fifo=1;
  - a logic pulse whose logic_to_fifo bit is 1 (bit 0 for logic 1, bit 1 for logic 2).

  A logic pulse with its logic_to_fifo bit at 0 sets its own flag (bit 4 or bit 5) instead.
- R11: irq equals, one clock later, the OR over the bitwise AND of the flags and irq_en[5:0].
- R12: Any address other than 0x00, 0x01 and 0x02 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| logic1_hit | input | 1 | Logic block 1 event pulse |
| logic2_hit | input | 1 | Logic block 2 event pulse |
| logic_to_fifo | input | 2 | Routes logic 1 / logic 2 pulses to the event flag |
| logic1_lvl | input | 1 | Live logic block 1 output |
| logic2_lvl | input | 1 | Live logic block 2 output |
| lock_evt | input | 1 | Lock or unlock event pulse |
| lock_sw_cause | input | 1 | The current lock change was made by software |
| locked | input | 1 | Live lock state, 1 = locked |
| ovf_hit | input | 1 | FIFO overflow pulse |
| key_evt | input | 1 | Key press or release pulse |
| gpi_hit | input | GPI_N | Per-pin GPI event pulses |
| gpi_to_fifo | input | GPI_N | Per-pin routing to FIFO |
| gpi_pend | input | GPI_N | Per-pin GPI flags still pending |
| evt_count | input | 5 | Events held in the FIFO |
| irq_en | input | 6 | Per-flag request enables |
| irq | output | 1 | Registered interrupt request |

## Verification
Two cases are hard to reach from the ports. The first is a source pulse that lands in the same cycle as a write-1 clear of the same flag. The second is a GPI clear attempted while a per-pin flag is still pending. The stimulus tasks drive the pulse and the write strobe on the same falling edge, and they hold gpi_pend high across a clear write before lowering it and clearing again. The lock-suppression path is covered by sending lock_evt both with and without lock_sw_cause, each time from a cleared flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NFLAG  = 6;
  localparam int B_EVT  = 0;
  localparam int B_GPI  = 1;
  localparam int B_OVF  = 2;
  localparam int B_LOCK = 3;
  localparam int B_LOG1 = 4;
  localparam int B_LOG2 = 5;
  localparam int EC_W   = 5;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam logic [AW-1:0] A_ID   = 8'h00;
  localparam logic [AW-1:0] A_INT  = 8'h01;
  localparam logic [AW-1:0] A_STAT = 8'h02;
  localparam logic [3:0]    MFR_ID = 4'b0001;
endpackage

// File: rtl/irq_source_map.sv
module irq_source_map
  import irq_pkg::*;
#(
  parameter int GPI_N = 8
) (
  input  logic             logic1_hit,
  input  logic             logic2_hit,
  input  logic [1:0]       logic_to_fifo,
  input  logic             lock_evt,
  input  logic             lock_sw_cause,
  input  logic             ovf_hit,
  input  logic             key_evt,
  input  logic [GPI_N-1:0] gpi_hit,
  input  logic [GPI_N-1:0] gpi_to_fifo,
  output logic [NFLAG-1:0] set_vec
);
  logic gpi_direct;
  logic gpi_fifo;

  // Split the GPI hits by routing: direct pins feed the GPI flag,
  // FIFO-routed pins feed the event flag.
  always_comb begin
    gpi_direct = |(gpi_hit & ~gpi_to_fifo);
    gpi_fifo   = |(gpi_hit & gpi_to_fifo);
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_LOG2] = logic2_hit & ~logic_to_fifo[1];
    set_vec[B_LOG1] = logic1_hit & ~logic_to_fifo[0];
    // A lock change caused by software raises no lock flag.
    set_vec[B_LOCK] = lock_evt & ~lock_sw_cause;
    set_vec[B_OVF]  = ovf_hit;
    set_vec[B_GPI]  = gpi_direct;
    set_vec[B_EVT]  = key_evt | gpi_fifo
                    | (logic1_hit & logic_to_fifo[0])
                    | (logic2_hit & logic_to_fifo[1]);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] keep,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic d;
    logic ce;

    // A set beats a clear in the same cycle; keep blocks the clear.
    always_comb begin
      ce = set[i] | (clr[i] & ~keep[i]);
      d  = set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (ce) q[i] <= d;
    end
  end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_pkg::*;
#(
  parameter logic [3:0] REV = 4'd1
) (
  input  logic [AW-1:0]    addr,
  input  logic [NFLAG-1:0] flags,
  input  logic             logic1_lvl,
  input  logic             logic2_lvl,
  input  logic             locked,
  input  logic [EC_W-1:0]  evt_count,
  output logic [DW-1:0]    rdata
);
  localparam int PAD = DW - NFLAG;

  always_comb begin
    unique case (addr)
      A_ID:    rdata = {MFR_ID, REV};
      A_INT:   rdata = {{PAD{1'b0}}, flags};
      A_STAT:  rdata = {logic2_lvl, logic1_lvl, locked, evt_count};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int         GPI_N = 8,
  parameter logic [3:0] REV   = 4'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             logic1_hit,
  input  logic             logic2_hit,
  input  logic [1:0]       logic_to_fifo,
  input  logic             logic1_lvl,
  input  logic             logic2_lvl,
  input  logic             lock_evt,
  input  logic             lock_sw_cause,
  input  logic             locked,
  input  logic             ovf_hit,
  input  logic             key_evt,
  input  logic [GPI_N-1:0] gpi_hit,
  input  logic [GPI_N-1:0] gpi_to_fifo,
  input  logic [GPI_N-1:0] gpi_pend,
  input  logic [EC_W-1:0]  evt_count,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] keep_vec;
  logic [NFLAG-1:0] stat_q;
  logic             irq_d;
  logic             irq_q;

  irq_source_map #(.GPI_N(GPI_N)) u_map (
    .logic1_hit    (logic1_hit),
    .logic2_hit    (logic2_hit),
    .logic_to_fifo (logic_to_fifo),
    .lock_evt      (lock_evt),
    .lock_sw_cause (lock_sw_cause),
    .ovf_hit       (ovf_hit),
    .key_evt       (key_evt),
    .gpi_hit       (gpi_hit),
    .gpi_to_fifo   (gpi_to_fifo),
    .set_vec       (set_vec)
  );

  // A write to the flag address clears the bits written as 1.
  always_comb begin
    clr_vec         = (reg_wr && reg_addr == A_INT) ? reg_wdata[NFLAG-1:0] : '0;
    keep_vec        = '0;
    keep_vec[B_GPI] = |gpi_pend;
  end

  irq_flag_bank #(.W(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_vec),
    .clr   (clr_vec),
    .keep  (keep_vec),
    .q     (stat_q)
  );

  irq_readback #(.REV(REV)) u_rd (
    .addr       (reg_addr),
    .flags      (stat_q),
    .logic1_lvl (logic1_lvl),
    .logic2_lvl (logic2_lvl),
    .locked     (locked),
    .evt_count  (evt_count),
    .rdata      (reg_rdata)
  );

  always_comb irq_d = |(stat_q & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int GPI_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             lock_evt,
  input logic             lock_sw_cause,
  input logic             logic1_hit,
  input logic             logic2_hit,
  input logic             ovf_hit,
  input logic             key_evt,
  input logic [GPI_N-1:0] gpi_pend,
  input logic [NFLAG-1:0] irq_en,
  input logic [NFLAG-1:0] stat,
  input logic             irq
);
  AST_ID_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_ID) |-> (reg_rdata[7:4] == MFR_ID)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_INT) |-> (reg_rdata[7:6] == 2'b00)); // R3
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_INT && !reg_wdata[B_OVF] && stat[B_OVF]) |=> stat[B_OVF]); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> stat[B_OVF]); // R5
  AST_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt && lock_sw_cause && !stat[B_LOCK]) |=> !stat[B_LOCK]); // R7
  AST_GPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[B_GPI] && (|gpi_pend)) |=> stat[B_GPI]); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat & irq_en)))); // R11
endmodule

bind irq_status_ctrl irq_status_chk #(.GPI_N(GPI_N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .lock_evt      (lock_evt),
  .lock_sw_cause (lock_sw_cause),
  .logic1_hit    (logic1_hit),
  .logic2_hit    (logic2_hit),
  .ovf_hit       (ovf_hit),
  .key_evt       (key_evt),
  .gpi_pend      (gpi_pend),
  .irq_en        (irq_en),
  .stat          (stat_q),
  .irq           (irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int GPI_N = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic             logic1_hit = 1'b0, logic2_hit = 1'b0;
  logic [1:0]       logic_to_fifo = '0;
  logic             logic1_lvl = 1'b0, logic2_lvl = 1'b0;
  logic             lock_evt = 1'b0, lock_sw_cause = 1'b0, locked = 1'b0;
  logic             ovf_hit = 1'b0, key_evt = 1'b0;
  logic [GPI_N-1:0] gpi_hit = '0, gpi_to_fifo = '0, gpi_pend = '0;
  logic [4:0]       evt_count = '0;
  logic [5:0]       irq_en = '0;
  logic             irq;

  always #10 clk = ~clk;

  irq_status_ctrl #(.GPI_N(GPI_N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .logic1_hit(logic1_hit), .logic2_hit(logic2_hit), .logic_to_fifo(logic_to_fifo),
    .logic1_lvl(logic1_lvl), .logic2_lvl(logic2_lvl),
    .lock_evt(lock_evt), .lock_sw_cause(lock_sw_cause), .locked(locked),
    .ovf_hit(ovf_hit), .key_evt(key_evt),
    .gpi_hit(gpi_hit), .gpi_to_fifo(gpi_to_fifo), .gpi_pend(gpi_pend),
    .evt_count(evt_count), .irq_en(irq_en), .irq(irq)
  );

  typedef struct {
    string      tag;
    logic [7:0] exp;
    bit         is_irq;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  event  smp;

  // Monitor: pops the expected items and compares them with the outputs.
  initial begin
    forever begin
      @(smp);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {7'b0, irq} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  // Driver side: sets the address, pushes the expected value, then samples.
  task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #1;
    q.push_back('{tag: tag, exp: e, is_irq: 1'b0});
    ->smp;
    #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    q.push_back('{tag: tag, exp: {7'b0, e}, is_irq: 1'b1});
    ->smp;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 / R2: reset state and identity byte
    chk_reg(8'h01, 8'h00, "R1 flags after reset");
    chk_irq(1'b0, "R1 irq after reset");
    chk_reg(8'h00, 8'h11, "R2 identity byte");

    // R4: sticky overflow, write 0 has no effect, write 1 clears
    ovf_hit = 1'b1; tick(); ovf_hit = 1'b0;
    chk_reg(8'h01, 8'h04, "R4 overflow set");
    wr(8'h01, 8'hFB);
    chk_reg(8'h01, 8'h04, "R4 write 0 keeps flag");
    wr(8'h01, 8'h04);
    chk_reg(8'h01, 8'h00, "R4 write 1 clears flag");

    // R5: set and clear in the same cycle
    ovf_hit = 1'b1; wr(8'h01, 8'h04); ovf_hit = 1'b0;
    chk_reg(8'h01, 8'h04, "R5 set beats clear");
    wr(8'h01, 8'hFF);

    // R6: live status byte
    logic2_lvl = 1'b1; logic1_lvl = 1'b0; locked = 1'b1; evt_count = 5'd19;
    chk_reg(8'h02, 8'hB3, "R6 live status A");
    logic2_lvl = 1'b0; logic1_lvl = 1'b1; locked = 1'b0; evt_count = 5'd4;
    chk_reg(8'h02, 8'h44, "R6 live status B");

    // R7: lock event masked when software caused it
    lock_evt = 1'b1; lock_sw_cause = 1'b1; tick(); lock_evt = 1'b0; lock_sw_cause = 1'b0;
    chk_reg(8'h01, 8'h00, "R7 software lock change masked");
    lock_evt = 1'b1; tick(); lock_evt = 1'b0;
    chk_reg(8'h01, 8'h08, "R7 lock event sets flag");
    wr(8'h01, 8'h08);

    // R8 / R10: GPI routing
    gpi_to_fifo = 8'h0F;
    gpi_hit = 8'h01; tick(); gpi_hit = '0;
    chk_reg(8'h01, 8'h01, "R8 R10 FIFO pin sets event only");
    wr(8'h01, 8'h01);
    gpi_hit = 8'h10; tick(); gpi_hit = '0;
    chk_reg(8'h01, 8'h02, "R8 direct pin sets GPI flag");

    // R9: GPI clear blocked while a pin flag is pending
    gpi_pend = 8'h20; wr(8'h01, 8'h02);
    chk_reg(8'h01, 8'h02, "R9 clear ignored while pending");
    gpi_pend = '0; wr(8'h01, 8'h02);
    chk_reg(8'h01, 8'h00, "R9 clear accepted after pending drops");

    // R10 / R3: logic routing
    logic_to_fifo = 2'b01;
    logic1_hit = 1'b1; tick(); logic1_hit = 1'b0;
    chk_reg(8'h01, 8'h01, "R10 routed logic1 sets event");
    logic2_hit = 1'b1; tick(); logic2_hit = 1'b0;
    chk_reg(8'h01, 8'h21, "R10 unrouted logic2 sets bit 5");
    wr(8'h01, 8'h21);
    logic_to_fifo = 2'b00;
    logic1_hit = 1'b1; tick(); logic1_hit = 1'b0;
    chk_reg(8'h01, 8'h10, "R3 logic1 flag at bit 4");
    wr(8'h01, 8'h10);

    // R3: all flags together, reserved bits stay 0
    logic1_hit = 1'b1; logic2_hit = 1'b1; lock_evt = 1'b1; ovf_hit = 1'b1;
    key_evt = 1'b1; gpi_hit = 8'h80;
    tick();
    logic1_hit = 1'b0; logic2_hit = 1'b0; lock_evt = 1'b0; ovf_hit = 1'b0;
    key_evt = 1'b0; gpi_hit = '0;
    chk_reg(8'h01, 8'h3F, "R3 all flags, reserved zero");
    wr(8'h01, 8'hFF);
    chk_reg(8'h01, 8'h00, "R4 clear all");

    // R11: request line with enables and one cycle of latency
    irq_en = 6'h00;
    ovf_hit = 1'b1; tick(); ovf_hit = 1'b0;
    tick();
    chk_irq(1'b0, "R11 disabled flag gives no irq");
    irq_en = 6'h04;
    tick();
    chk_irq(1'b1, "R11 enabled flag raises irq");
    wr(8'h01, 8'h04);
    chk_irq(1'b1, "R11 irq lags clear by one cycle");
    tick();
    chk_irq(1'b0, "R11 irq drops after clear");
    key_evt = 1'b1; tick(); key_evt = 1'b0;
    irq_en = 6'h01;
    chk_irq(1'b0, "R11 irq not yet raised");
    tick();
    chk_irq(1'b1, "R11 event flag raises irq");
    wr(8'h01, 8'h01);

    // R12: unmapped address
    chk_reg(8'h05, 8'h00, "R12 unmapped address");
    chk_reg(8'hFF, 8'h00, "R12 top address");

    tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule